// File: doc/BRIEF.md
# Five-Copy Majority Vote Storage

This block stores logical bytes for a host on top of a byte-wide nonvolatile memory port and protects each byte by keeping five copies of it. The logical address space is one fifth of the physical array. Copy k of logical address A sits at physical address A + k*STRIDE, where STRIDE is the physical depth divided by five. This spreads the copies across the whole array, so damage to one region of the array hits only one copy.

A logical write stores the byte in all five copy slots, one copy per cycle. A logical read fetches the five copies one after another and compares them. Five matching copies are returned unchanged and nothing is written. If the copies disagree but one value is held by at least three of them, that value is returned and written back to all five slots before the response. If no value reaches three copies, copy 0 is returned and an uncorrectable flag is raised. Nothing is written back in that case.

The host uses a valid/ready request channel. Each accepted request, read or write, ends with a single-cycle response. Only one request is active at a time.

Top module: `quint_vote_store`

## Requirements
- R1: Copy k (k = 0..4) of logical address A is accessed at physical address A + k*STRIDE, with STRIDE = PHYS_DEPTH/5 (64 by default), and every access stays below PHYS_DEPTH.
- R2: A write request issues exactly five memory writes of the request byte, in copy order k = 0,1,2,3,4. Its response carries both flags low.
- R3: A read request issues exactly five memory reads, one per copy, in copy order k = 0,1,2,3,4.
- R4: When all five copies are equal, the read response returns that value, both flags are low, and no memory write takes place.
- R5: When the copies disagree and one value is held by three or more copies, the read response returns that value, even if copy 0 is one of the damaged copies.
- R6: After a resolved disagreement, all five copies are rewritten with the voted value, in order k = 0..4, before the response is given. The response raises the corrected flag. A later read of the same address finds all copies equal.
- R7: When no value is held by three or more copies, the response returns copy 0 and raises the uncorrectable flag. No memory write takes place, so a repeat read reports the same result.
- R8: req_ready is low from the cycle after a request is accepted through its response cycle. A request presented during that time is neither accepted nor performed.
- R9: After reset, req_ready is high and rsp_valid and mem_en are low.
- R10: rsp_valid is high for exactly one cycle per request. rsp_corrected and rsp_uncorrectable are never both high, and each is high only together with rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = store, 0 = fetch |
| req_addr | input | LOG_AW (6) | Logical byte address, below STRIDE |
| req_wdata | input | DATA_W (8) | Byte to store |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_rdata | output | DATA_W (8) | Fetched or voted byte (stored byte on writes) |
| rsp_corrected | output | 1 | Copies disagreed and were repaired |
| rsp_uncorrectable | output | 1 | No value reached three copies |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | PHYS_AW (9) | Physical address |
| mem_wdata | output | DATA_W (8) | Write byte |
| mem_rdata | input | DATA_W (8) | Read byte, valid the cycle after a read access |

## Verification
The hardest states to reach from the host side are those where the stored copies disagree, because every host write makes all five copies equal. The bench memory model therefore has a separate fault-injection path that overwrites chosen physical cells while the block is idle. This path creates two damaged copies holding different values, two damaged copies holding the same value (including copy 0), and a two-two-one split with no majority. Each case is followed by a repeat read, which shows whether the repair happened or was correctly withheld.

// File: rtl/qvs_pkg.sv
package qvs_pkg;
  localparam int NCOPY  = 5;
  localparam int CIDX_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_RD_LAST,
    ST_VOTE,
    ST_FIX,
    ST_RESP
  } qvs_state_e;
endpackage

// File: rtl/qvs_addr_map.sv
module qvs_addr_map
  import qvs_pkg::*;
#(
  parameter int LOG_AW  = 6,
  parameter int PHYS_AW = 9,
  parameter int STRIDE  = 64
) (
  input  logic [LOG_AW-1:0]  log_addr,
  input  logic [CIDX_W-1:0]  copy_idx,
  output logic [PHYS_AW-1:0] phys_addr
);
  logic [PHYS_AW-1:0] offset;

  always_comb begin
    offset    = PHYS_AW'(STRIDE) * PHYS_AW'(copy_idx);
    phys_addr = PHYS_AW'(log_addr) + offset;
  end
endmodule

// File: rtl/qvs_copy_buf.sv
module qvs_copy_buf
  import qvs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          cap_en,
  input  logic [CIDX_W-1:0]             cap_idx,
  input  logic [DATA_W-1:0]             rdata,
  output logic [NCOPY-1:0][DATA_W-1:0]  copies
);
  for (genvar i = 0; i < NCOPY; i++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    logic              slot_en;

    assign slot_en = cap_en && (cap_idx == CIDX_W'(i));

    always_ff @(posedge clk) begin
      if (slot_en) slot_q <= rdata;
    end

    assign copies[i] = slot_q;
  end
endmodule

// File: rtl/qvs_voter.sv
module qvs_voter
  import qvs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [NCOPY-1:0][DATA_W-1:0] copies,
  output logic                         all_agree,
  output logic                         has_major,
  output logic [DATA_W-1:0]            major_val
);
  localparam int CNT_W  = $clog2(NCOPY + 1);
  localparam int QUORUM = NCOPY / 2 + 1;

  logic [NCOPY-1:0][CNT_W-1:0] votes;

  for (genvar i = 0; i < NCOPY; i++) begin : g_tally
    logic [CNT_W-1:0] tally;
    always_comb begin
      tally = '0;
      for (int j = 0; j < NCOPY; j++) begin
        if (copies[i] == copies[j]) tally = tally + CNT_W'(1);
      end
    end
    assign votes[i] = tally;
  end

  always_comb begin
    all_agree = (votes[0] == CNT_W'(NCOPY));
    has_major = 1'b0;
    major_val = copies[0];
    for (int i = NCOPY - 1; i >= 0; i--) begin
      if (votes[i] >= CNT_W'(QUORUM)) begin
        has_major = 1'b1;
        major_val = copies[i];
      end
    end
  end
endmodule

// File: rtl/qvs_ctrl.sv
module qvs_ctrl
  import qvs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LOG_AW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [LOG_AW-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                req_ready,
  input  logic                all_agree,
  input  logic                has_major,
  input  logic [DATA_W-1:0]   major_val,
  input  logic [DATA_W-1:0]   copy0,
  output logic [LOG_AW-1:0]   cur_addr,
  output logic [CIDX_W-1:0]   cur_copy,
  output logic                mem_en,
  output logic                mem_we,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                cap_en,
  output logic [CIDX_W-1:0]   cap_idx,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_corrected,
  output logic                rsp_uncorrectable
);
  localparam logic [CIDX_W-1:0] LAST_COPY = CIDX_W'(NCOPY - 1);

  qvs_state_e          state_q, state_d;
  logic [CIDX_W-1:0]   copy_q, copy_d;
  logic [LOG_AW-1:0]   addr_q;
  logic [DATA_W-1:0]   data_q, data_d;
  logic                addr_en, data_en;
  logic                cap_q, cap_d;
  logic [CIDX_W-1:0]   capi_q, capi_d;
  logic                corr_q, corr_d;
  logic                unc_q, unc_d;

  always_comb begin
    state_d = state_q;
    copy_d  = copy_q;
    data_d  = data_q;
    addr_en = 1'b0;
    data_en = 1'b0;
    cap_d   = 1'b0;
    capi_d  = capi_q;
    corr_d  = corr_q;
    unc_d   = unc_q;
    mem_en  = 1'b0;
    mem_we  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          addr_en = 1'b1;
          data_en = 1'b1;
          data_d  = req_wdata;
          copy_d  = '0;
          corr_d  = 1'b0;
          unc_d   = 1'b0;
          state_d = req_write ? ST_WR : ST_RD;
        end
      end
      ST_WR, ST_FIX: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
        if (copy_q == LAST_COPY) state_d = ST_RESP;
        else copy_d = copy_q + CIDX_W'(1);
      end
      ST_RD: begin
        mem_en = 1'b1;
        cap_d  = 1'b1;
        capi_d = copy_q;
        if (copy_q == LAST_COPY) state_d = ST_RD_LAST;
        else copy_d = copy_q + CIDX_W'(1);
      end
      ST_RD_LAST: begin
        state_d = ST_VOTE;
      end
      ST_VOTE: begin
        data_en = 1'b1;
        if (all_agree) begin
          data_d  = copy0;
          state_d = ST_RESP;
        end else if (has_major) begin
          data_d  = major_val;
          corr_d  = 1'b1;
          copy_d  = '0;
          state_d = ST_FIX;
        end else begin
          data_d  = copy0;
          unc_d   = 1'b1;
          state_d = ST_RESP;
        end
      end
      ST_RESP: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      copy_q  <= '0;
      cap_q   <= 1'b0;
      capi_q  <= '0;
      corr_q  <= 1'b0;
      unc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      copy_q  <= copy_d;
      cap_q   <= cap_d;
      capi_q  <= capi_d;
      corr_q  <= corr_d;
      unc_q   <= unc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= req_addr;
    if (data_en) data_q <= data_d;
  end

  assign req_ready         = (state_q == ST_IDLE);
  assign cur_addr          = addr_q;
  assign cur_copy          = copy_q;
  assign mem_wdata         = data_q;
  assign cap_en            = cap_q;
  assign cap_idx           = capi_q;
  assign rsp_valid         = (state_q == ST_RESP);
  assign rsp_rdata         = data_q;
  assign rsp_corrected     = rsp_valid && corr_q;
  assign rsp_uncorrectable = rsp_valid && unc_q;
endmodule

// File: rtl/quint_vote_store.sv
module quint_vote_store
  import qvs_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int PHYS_DEPTH   = 320,
  localparam int STRIDE      = PHYS_DEPTH / NCOPY,
  localparam int LOG_AW      = $clog2(STRIDE),
  localparam int PHYS_AW     = $clog2(PHYS_DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [LOG_AW-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_corrected,
  output logic               rsp_uncorrectable,
  output logic               mem_en,
  output logic               mem_we,
  output logic [PHYS_AW-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata
);
  logic [1:0]                   rst_sync_q;
  logic                         rst_int_n;
  logic [LOG_AW-1:0]            cur_addr;
  logic [CIDX_W-1:0]            cur_copy;
  logic                         cap_en;
  logic [CIDX_W-1:0]            cap_idx;
  logic [NCOPY-1:0][DATA_W-1:0] copies;
  logic                         all_agree;
  logic                         has_major;
  logic [DATA_W-1:0]            major_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  qvs_ctrl #(.DATA_W(DATA_W), .LOG_AW(LOG_AW)) ctrl_i (
    .clk               (clk),
    .rst_n             (rst_int_n),
    .req_valid         (req_valid),
    .req_write         (req_write),
    .req_addr          (req_addr),
    .req_wdata         (req_wdata),
    .req_ready         (req_ready),
    .all_agree         (all_agree),
    .has_major         (has_major),
    .major_val         (major_val),
    .copy0             (copies[0]),
    .cur_addr          (cur_addr),
    .cur_copy          (cur_copy),
    .mem_en            (mem_en),
    .mem_we            (mem_we),
    .mem_wdata         (mem_wdata),
    .cap_en            (cap_en),
    .cap_idx           (cap_idx),
    .rsp_valid         (rsp_valid),
    .rsp_rdata         (rsp_rdata),
    .rsp_corrected     (rsp_corrected),
    .rsp_uncorrectable (rsp_uncorrectable)
  );

  qvs_addr_map #(.LOG_AW(LOG_AW), .PHYS_AW(PHYS_AW), .STRIDE(STRIDE)) map_i (
    .log_addr  (cur_addr),
    .copy_idx  (cur_copy),
    .phys_addr (mem_addr)
  );

  qvs_copy_buf #(.DATA_W(DATA_W)) buf_i (
    .clk     (clk),
    .cap_en  (cap_en),
    .cap_idx (cap_idx),
    .rdata   (mem_rdata),
    .copies  (copies)
  );

  qvs_voter #(.DATA_W(DATA_W)) vote_i (
    .copies    (copies),
    .all_agree (all_agree),
    .has_major (has_major),
    .major_val (major_val)
  );
endmodule

// File: rtl/quint_vote_store_chk.sv
module quint_vote_store_chk #(
  parameter int DATA_W     = 8,
  parameter int PHYS_DEPTH = 320,
  parameter int LOG_AW     = 6,
  parameter int PHYS_AW    = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [LOG_AW-1:0]  req_addr,
  input logic [DATA_W-1:0]  req_wdata,
  input logic               rsp_valid,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic               rsp_corrected,
  input logic               rsp_uncorrectable,
  input logic               mem_en,
  input logic               mem_we,
  input logic [PHYS_AW-1:0] mem_addr,
  input logic [DATA_W-1:0]  mem_wdata,
  input logic [DATA_W-1:0]  mem_rdata
);
  assert_addr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (32'(mem_addr) < PHYS_DEPTH));

  assert_repair_before_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_corrected) |-> $past(mem_en && mem_we));

  assert_no_access_uncorr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_uncorrectable) |-> $past(!mem_en));

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_mem_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !req_ready);

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_flag_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_corrected || rsp_uncorrectable) |-> rsp_valid);

  assert_flag_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_corrected && rsp_uncorrectable));
endmodule

bind quint_vote_store quint_vote_store_chk #(
  .DATA_W(DATA_W), .PHYS_DEPTH(PHYS_DEPTH), .LOG_AW(LOG_AW), .PHYS_AW(PHYS_AW)
) chk_i (.*);

// File: tb/quint_vote_store_tb_top.sv
module quint_vote_store_tb_top;
  localparam int DW     = 8;
  localparam int DEPTH  = 320;
  localparam int STRIDE = DEPTH / 5;
  localparam int LAW    = $clog2(STRIDE);
  localparam int PAW    = $clog2(DEPTH);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_write = 1'b0;
  logic [LAW-1:0] req_addr = '0;
  logic [DW-1:0]  req_wdata = '0;
  logic           req_ready;
  logic           rsp_valid;
  logic [DW-1:0]  rsp_rdata;
  logic           rsp_corrected;
  logic           rsp_uncorrectable;
  logic           mem_en;
  logic           mem_we;
  logic [PAW-1:0] mem_addr;
  logic [DW-1:0]  mem_wdata;
  logic [DW-1:0]  mem_rdata = '0;

  always #5 clk = ~clk;

  quint_vote_store #(.DATA_W(DW), .PHYS_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_corrected(rsp_corrected), .rsp_uncorrectable(rsp_uncorrectable),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model with access log and fault injection
  logic [DW-1:0]  mem [0:DEPTH-1];
  logic           inj_en = 1'b0;
  logic [PAW-1:0] inj_addr = '0;
  logic [DW-1:0]  inj_data = '0;
  int             log_cnt = 0;
  logic [PAW-1:0] log_addr [0:63];
  logic           log_we   [0:63];
  logic [DW-1:0]  log_dat  [0:63];

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata     <= mem[mem_addr];
      log_addr[log_cnt % 64] <= mem_addr;
      log_we[log_cnt % 64]   <= mem_we;
      log_dat[log_cnt % 64]  <= mem_wdata;
      log_cnt <= log_cnt + 1;
    end else if (inj_en) begin
      mem[inj_addr] <= inj_data;
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] r_data;
  logic r_corr, r_unc;
  int r_start, r_n;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic [LAW-1:0] a, input logic [DW-1:0] d);
    int guard;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    guard = 0;
    while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
    r_start = log_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 50) begin @(negedge clk); guard++; end
    chk(rsp_valid, "R10 response arrives", 32'(rsp_valid), 1);
    r_data = rsp_rdata; r_corr = rsp_corrected; r_unc = rsp_uncorrectable;
    r_n = log_cnt - r_start;
    @(negedge clk);
    chk(!rsp_valid, "R10 response one cycle", 32'(rsp_valid), 0);
  endtask

  task automatic inject(input int la, input int k, input logic [DW-1:0] v);
    @(negedge clk);
    inj_en = 1'b1; inj_addr = PAW'(la + k * STRIDE); inj_data = v;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  // five log entries from position s: same direction, copy order, optional data
  task automatic chk_seq(input int s, input int la, input logic we, input bit chk_d,
                         input logic [DW-1:0] v, input string tag);
    for (int k = 0; k < 5; k++) begin
      chk(log_addr[(s + k) % 64] == PAW'(la + k * STRIDE), tag,
          32'(log_addr[(s + k) % 64]), 32'(la + k * STRIDE));
      chk(log_we[(s + k) % 64] == we, tag, 32'(log_we[(s + k) % 64]), 32'(we));
      if (chk_d) chk(log_dat[(s + k) % 64] == v, tag, 32'(log_dat[(s + k) % 64]), 32'(v));
    end
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R9 ready after reset", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R9 rsp_valid after reset", 32'(rsp_valid), 0);
    chk(mem_en == 1'b0, "R9 mem_en after reset", 32'(mem_en), 0);
  endtask

  task automatic t_write_clean_read;
    do_req(1'b1, LAW'(5), 8'h3C);
    chk(r_n == 5, "R2 write count", 32'(r_n), 5);
    chk_seq(r_start, 5, 1'b1, 1'b1, 8'h3C, "R1 R2 write copies");
    chk(!r_corr && !r_unc, "R2 write flags", {30'd0, r_corr, r_unc}, 0);
    do_req(1'b0, LAW'(5), 8'h00);
    chk(r_n == 5, "R4 clean read access count", 32'(r_n), 5);
    chk_seq(r_start, 5, 1'b0, 1'b0, 8'h00, "R3 read order");
    chk(r_data == 8'h3C, "R4 clean read data", 32'(r_data), 32'h3C);
    chk(!r_corr && !r_unc, "R4 clean read flags", {30'd0, r_corr, r_unc}, 0);
  endtask

  task automatic t_repair_distinct;
    inject(5, 1, 8'h11);
    inject(5, 3, 8'h22);
    do_req(1'b0, LAW'(5), 8'h00);
    chk(r_data == 8'h3C, "R5 majority data", 32'(r_data), 32'h3C);
    chk(r_corr && !r_unc, "R6 corrected flag", {30'd0, r_corr, r_unc}, 2);
    chk(r_n == 10, "R6 repair access count", 32'(r_n), 10);
    chk_seq(r_start + 5, 5, 1'b1, 1'b1, 8'h3C, "R6 repair writes");
    do_req(1'b0, LAW'(5), 8'h00);
    chk(!r_corr && !r_unc && r_n == 5, "R6 repaired copies agree", 32'(r_n), 5);
  endtask

  task automatic t_repair_copy0;
    inject(5, 0, 8'h77);
    inject(5, 4, 8'h77);
    do_req(1'b0, LAW'(5), 8'h00);
    chk(r_data == 8'h3C, "R5 majority with copy0 damaged", 32'(r_data), 32'h3C);
    chk(r_corr, "R6 corrected copy0 case", 32'(r_corr), 1);
    chk_seq(r_start + 5, 5, 1'b1, 1'b1, 8'h3C, "R6 repair copy0 case");
  endtask

  task automatic t_uncorrectable;
    do_req(1'b1, LAW'(STRIDE - 1), 8'hA5);
    chk_seq(r_start, STRIDE - 1, 1'b1, 1'b1, 8'hA5, "R1 top logical address");
    inject(STRIDE - 1, 1, 8'h01);
    inject(STRIDE - 1, 2, 8'h01);
    inject(STRIDE - 1, 3, 8'h02);
    inject(STRIDE - 1, 4, 8'h02);
    for (int rep = 0; rep < 2; rep++) begin
      do_req(1'b0, LAW'(STRIDE - 1), 8'h00);
      chk(r_data == 8'hA5, "R7 returns copy0", 32'(r_data), 32'hA5);
      chk(r_unc && !r_corr, "R7 uncorrectable flag", {30'd0, r_corr, r_unc}, 1);
      chk(r_n == 5, "R7 no writes", 32'(r_n), 5);
    end
  endtask

  task automatic t_busy;
    int seen, guard, s;
    seen = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = LAW'(9); req_wdata = 8'h44;
    s = log_cnt;
    @(negedge clk);
    req_addr = LAW'(5); req_wdata = 8'hEE;
    guard = 0;
    while (!rsp_valid && guard < 50) begin
      if (req_ready) seen++;
      @(negedge clk); guard++;
    end
    if (req_ready) seen++;
    req_valid = 1'b0;
    chk(seen == 0, "R8 ready low while busy", 32'(seen), 0);
    chk(log_cnt - s == 5, "R8 only one request performed", 32'(log_cnt - s), 5);
    chk_seq(s, 9, 1'b1, 1'b1, 8'h44, "R8 accepted request");
    @(negedge clk);
    do_req(1'b0, LAW'(5), 8'h00);
    chk(r_data == 8'h3C, "R8 busy request ignored", 32'(r_data), 32'h3C);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset;
        t_write_clean_read;
        t_repair_distinct;
        t_repair_copy0;
        t_uncorrectable;
        t_busy;
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule